// File: doc/BRIEF.md
# Configurable Block Clock Strobe Generator

This block derives four clock lines for one small logic block of a programmable array. It runs entirely in a single fast system clock. Four global clock inputs and two product-term inputs are brought into that domain by a synchronizer. Each line is then delivered as a strobe one system cycle wide, marking the active edge that downstream macrocells should act on. No clock signal is ever muxed or gated directly.

The four lines have different capabilities. Line 0 follows either a chosen global clock or the first product term. Line 1 follows a chosen global clock on its rising edge, its falling edge, or both edges, and each edge has its own enable. Line 2 follows the rising edge of a chosen global clock, with an optional enable. Line 3 is either the complement of line 2, meaning the falling edge of the same clock gated by the same enable, or the rising edge of the second product term. The product-term choice for line 3 is only legal while line 2 does not use its enable. A request that breaks this rule is forced to the complement mode and leaves a sticky error flag set.

Configuration is applied as a static set of pins. These pins are copied into internal registers only in cycles where `cfg_load` is high.

Top module: `blkclk_gen`

## Requirements
- R1: While `rst_n` is low, `strobe` is 0 and `cfg_err` is 0. After reset the stored configuration is all zero: line 0 follows the rising edge of global clock 0, line 1 follows the rising edge of global clock 0, line 2 follows the rising edge of global clock 0 with no enable, and line 3 is the complement of line 2.
- R2: A global clock level change applied between edges k-1 and k makes the matching strobe high for exactly the cycle that follows edge k+2, and low again after edge k+3.
- R3: Each of lines 0, 1 and 2 uses a 2-bit select (`cfg_l0_sel`, `cfg_l1_sel`, `cfg_l2_sel`) to pick one of `gclk_in[3:0]`. Transitions on the other global clocks do not affect that line.
- R4: With `cfg_l0_pt`=1, line 0 (`strobe[0]`) strobes on rising edges of `pterm_in[0]` and ignores every global clock.
- R5: Line 1 uses `cfg_l1_mode` 2'b00 for rising edges and 2'b01 for falling edges. In both modes the edge is gated by `en_in[0]`.
- R6: With `cfg_l1_mode` 2'b10 or 2'b11, line 1 strobes on rising edges gated by `en_in[0]` and on falling edges gated by `en_in[1]`.
- R7: Line 2 (`strobe[2]`) strobes on rising edges of its selected clock. When `cfg_l2_use_en`=1 it strobes only if `en_in[2]` is 1.
- R8: With `cfg_l3_pt`=0, line 3 (`strobe[3]`) strobes on falling edges of line 2's selected clock, using the same enable gating as line 2.
- R9: With `cfg_l3_pt`=1 and `cfg_l2_use_en`=0, line 3 strobes on rising edges of `pterm_in[1]` and ignores global clocks.
- R10: Loading `cfg_l3_pt`=1 together with `cfg_l2_use_en`=1 sets `cfg_err` and makes line 3 behave as the complement of line 2. `cfg_err` stays set until reset, including across later legal loads.
- R11: Configuration pins that change while `cfg_load` is 0 have no effect on any strobe.
- R12: If no configuration was loaded at the edge in between, lines 0, 2 and 3 never strobe in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and strobes run on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gclk_in | input | 4 | Global clock inputs, asynchronous to `clk` |
| pterm_in | input | 2 | Product-term clock sources: bit 0 for line 0, bit 1 for line 3 |
| en_in | input | 3 | Enables: bit 0 line 1 primary, bit 1 line 1 falling edge in biphase, bit 2 lines 2 and 3 |
| cfg_load | input | 1 | Copies the configuration pins into the block while high |
| cfg_l0_pt | input | 1 | Line 0 uses the product term instead of a global clock |
| cfg_l0_sel | input | 2 | Global clock select for line 0 |
| cfg_l1_sel | input | 2 | Global clock select for line 1 |
| cfg_l1_mode | input | 2 | Line 1 edge mode: 00 rising, 01 falling, 1x both edges |
| cfg_l2_sel | input | 2 | Global clock select for lines 2 and 3 |
| cfg_l2_use_en | input | 1 | Line 2 (and line 3 complement) gated by `en_in[2]` |
| cfg_l3_pt | input | 1 | Line 3 uses the product term instead of the complement |
| strobe | output | 4 | One-cycle edge strobes, bit n for line n |
| cfg_err | output | 1 | Sticky flag for an illegal line 3 product-term request |

## Verification
A table drives one rising and then one falling transition on chosen global clocks or product terms under many configurations, and collects which lines strobe in each phase. Because every line's rise and fall response is recorded, the table separates several behaviours: the selected clock from the unselected ones, rising-edge modes from falling-edge modes, the two biphase enables from each other, gated from ungated lines, and product-term sources from global clocks. Directed tests then measure the exact strobe latency and width. They also confirm that pin changes without `cfg_load` have no effect, that an illegal line 3 request falls back to the complement mode with a sticky flag, and that reset restores the default configuration.

// File: rtl/blkclk_pkg.sv
package blkclk_pkg;

  localparam int unsigned GCLK_SEL_W = 2;
  localparam int unsigned NUM_LINES  = 4;
  localparam int unsigned NUM_EN     = 3;

  typedef enum logic [1:0] {
    L1_RISE   = 2'b00,
    L1_FALL   = 2'b01,
    L1_BOTH   = 2'b10,
    L1_BOTH_B = 2'b11
  } l1_mode_e;

  typedef struct packed {
    logic                  l0_pt;
    logic [GCLK_SEL_W-1:0] l0_sel;
    logic [GCLK_SEL_W-1:0] l1_sel;
    l1_mode_e              l1_mode;
    logic [GCLK_SEL_W-1:0] l2_sel;
    logic                  l2_use_en;
    logic                  l3_pt;
  } blk_cfg_t;

endpackage

// File: rtl/blkclk_sync.sv
module blkclk_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;
  logic [W-1:0]             prev_q;
  logic [W-1:0]             prev_d;

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < int'(STAGES); s++) begin
      stage_d[s] = stage_q[s-1];
    end
    prev_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= prev_d;
    end
  end

  assign cur  = stage_q[STAGES-1];
  assign prev = prev_q;

endmodule

// File: rtl/blkclk_cfg.sv
module blkclk_cfg
  import blkclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  blk_cfg_t cfg_d,
  output blk_cfg_t cfg_q,
  output logic     err_q
);

  blk_cfg_t cfg_n;
  blk_cfg_t cfg_r;
  logic     err_n;
  logic     err_r;
  logic     illegal;

  // Product-term clock on line 3 conflicts with an enabled line 2.
  assign illegal = cfg_d.l3_pt & cfg_d.l2_use_en;

  always_comb begin
    cfg_n = cfg_r;
    err_n = err_r;
    if (load) begin
      cfg_n = cfg_d;
      if (illegal) begin
        cfg_n.l3_pt = 1'b0;
        err_n       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= '0;
      err_r <= 1'b0;
    end else begin
      cfg_r <= cfg_n;
      err_r <= err_n;
    end
  end

  assign cfg_q = cfg_r;
  assign err_q = err_r;

endmodule

// File: rtl/blkclk_lines.sv
module blkclk_lines
  import blkclk_pkg::*;
#(
  parameter int unsigned NUM_GCLK = 4
) (
  input  blk_cfg_t              cfg,
  input  logic [NUM_GCLK+1:0]   s_cur,
  input  logic [NUM_GCLK+1:0]   s_prev,
  input  logic [NUM_EN-1:0]     en,
  output logic [NUM_LINES-1:0]  strobe_d
);

  localparam int unsigned PT0 = NUM_GCLK;
  localparam int unsigned PT1 = NUM_GCLK + 1;

  logic [NUM_GCLK-1:0] g_rise;
  logic [NUM_GCLK-1:0] g_fall;
  logic                pt0_rise;
  logic                pt1_rise;
  logic                l1_r;
  logic                l1_f;
  logic                l2_gate;

  always_comb begin
    g_rise   = s_cur[NUM_GCLK-1:0] & ~s_prev[NUM_GCLK-1:0];
    g_fall   = ~s_cur[NUM_GCLK-1:0] & s_prev[NUM_GCLK-1:0];
    pt0_rise = s_cur[PT0] & ~s_prev[PT0];
    pt1_rise = s_cur[PT1] & ~s_prev[PT1];
  end

  always_comb begin
    l1_r    = g_rise[cfg.l1_sel];
    l1_f    = g_fall[cfg.l1_sel];
    l2_gate = ~cfg.l2_use_en | en[2];

    strobe_d[0] = cfg.l0_pt ? pt0_rise : g_rise[cfg.l0_sel];

    unique case (cfg.l1_mode)
      L1_RISE: strobe_d[1] = l1_r & en[0];
      L1_FALL: strobe_d[1] = l1_f & en[0];
      default: strobe_d[1] = (l1_r & en[0]) | (l1_f & en[1]);
    endcase

    strobe_d[2] = g_rise[cfg.l2_sel] & l2_gate;
    strobe_d[3] = cfg.l3_pt ? pt1_rise : (g_fall[cfg.l2_sel] & l2_gate);
  end

endmodule

// File: rtl/blkclk_gen.sv
module blkclk_gen
  import blkclk_pkg::*;
#(
  parameter int unsigned NUM_GCLK    = 4,
  parameter int unsigned NUM_PT      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GCLK-1:0]   gclk_in,
  input  logic [NUM_PT-1:0]     pterm_in,
  input  logic [NUM_EN-1:0]     en_in,
  input  logic                  cfg_load,
  input  logic                  cfg_l0_pt,
  input  logic [GCLK_SEL_W-1:0] cfg_l0_sel,
  input  logic [GCLK_SEL_W-1:0] cfg_l1_sel,
  input  logic [1:0]            cfg_l1_mode,
  input  logic [GCLK_SEL_W-1:0] cfg_l2_sel,
  input  logic                  cfg_l2_use_en,
  input  logic                  cfg_l3_pt,
  output logic [NUM_LINES-1:0]  strobe,
  output logic                  cfg_err
);

  localparam int unsigned SYNC_W = NUM_GCLK + NUM_PT;

  blk_cfg_t             cfg_pins;
  blk_cfg_t             eff_cfg;
  logic [SYNC_W-1:0]    s_cur;
  logic [SYNC_W-1:0]    s_prev;
  logic [NUM_LINES-1:0] strobe_d;
  logic [NUM_LINES-1:0] strobe_q;

  always_comb begin
    cfg_pins.l0_pt     = cfg_l0_pt;
    cfg_pins.l0_sel    = cfg_l0_sel;
    cfg_pins.l1_sel    = cfg_l1_sel;
    cfg_pins.l1_mode   = l1_mode_e'(cfg_l1_mode);
    cfg_pins.l2_sel    = cfg_l2_sel;
    cfg_pins.l2_use_en = cfg_l2_use_en;
    cfg_pins.l3_pt     = cfg_l3_pt;
  end

  blkclk_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .cfg_d (cfg_pins),
    .cfg_q (eff_cfg),
    .err_q (cfg_err)
  );

  blkclk_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({pterm_in, gclk_in}),
    .cur      (s_cur),
    .prev     (s_prev)
  );

  blkclk_lines #(
    .NUM_GCLK (NUM_GCLK)
  ) u_lines (
    .cfg      (eff_cfg),
    .s_cur    (s_cur),
    .s_prev   (s_prev),
    .en       (en_in),
    .strobe_d (strobe_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  assign strobe = strobe_q;

endmodule

// File: rtl/blkclk_gen_chk.sv
module blkclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_load,
  input logic       cfg_l3_pt,
  input logic       cfg_l2_use_en,
  input logic [2:0] en_in,
  input logic [3:0] strobe,
  input logic       cfg_err,
  input logic       use_en_q
);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_load && cfg_l3_pt && cfg_l2_use_en));

  assert_line2_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[2] |-> (!$past(use_en_q) || $past(en_in[2])));

  assert_line0_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[0] && !$past(cfg_load)) |=> !strobe[0]);

  assert_line2_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[2] && !$past(cfg_load)) |=> !strobe[2]);

  assert_line3_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[3] && !$past(cfg_load)) |=> !strobe[3]);

endmodule

bind blkclk_gen blkclk_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_load      (cfg_load),
  .cfg_l3_pt     (cfg_l3_pt),
  .cfg_l2_use_en (cfg_l2_use_en),
  .en_in         (en_in),
  .strobe        (strobe),
  .cfg_err       (cfg_err),
  .use_en_q      (eff_cfg.l2_use_en)
);

// File: tb/blkclk_gen_test.sv
module blkclk_gen_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV         = 16;

  typedef struct packed {
    logic       l0pt;
    logic [1:0] l0sel;
    logic [1:0] l1sel;
    logic [1:0] l1mode;
    logic [1:0] l2sel;
    logic       l2en;
    logic       l3pt;
    logic [2:0] en;
    logic [5:0] stim;   // [3:0] global clocks, [4] pterm 0, [5] pterm 1
    logic [3:0] erise;
    logic [3:0] efall;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0,2'd0,2'd1,2'd0,2'd2,1'b0,1'b0,3'b000,6'h01,4'b0001,4'b0000,4'd3},  // R3
    '{1'b0,2'd0,2'd1,2'd0,2'd2,1'b0,1'b0,3'b001,6'h02,4'b0010,4'b0000,4'd5},  // R5
    '{1'b0,2'd3,2'd3,2'd1,2'd3,1'b0,1'b0,3'b001,6'h08,4'b0101,4'b1010,4'd8},  // R8
    '{1'b0,2'd1,2'd2,2'd1,2'd2,1'b1,1'b0,3'b000,6'h04,4'b0000,4'b0000,4'd7},  // R7
    '{1'b0,2'd1,2'd2,2'd1,2'd2,1'b1,1'b0,3'b100,6'h04,4'b0100,4'b1000,4'd7},  // R7
    '{1'b0,2'd1,2'd0,2'd2,2'd1,1'b0,1'b0,3'b001,6'h01,4'b0010,4'b0000,4'd6},  // R6
    '{1'b0,2'd1,2'd0,2'd2,2'd1,1'b0,1'b0,3'b010,6'h01,4'b0000,4'b0010,4'd6},  // R6
    '{1'b0,2'd1,2'd0,2'd3,2'd1,1'b0,1'b0,3'b011,6'h01,4'b0010,4'b0010,4'd6},  // R6
    '{1'b1,2'd0,2'd1,2'd0,2'd1,1'b0,1'b0,3'b000,6'h10,4'b0001,4'b0000,4'd4},  // R4
    '{1'b1,2'd0,2'd1,2'd0,2'd1,1'b0,1'b0,3'b000,6'h01,4'b0000,4'b0000,4'd4},  // R4
    '{1'b0,2'd1,2'd1,2'd0,2'd0,1'b0,1'b1,3'b000,6'h20,4'b1000,4'b0000,4'd9},  // R9
    '{1'b0,2'd1,2'd1,2'd0,2'd0,1'b0,1'b1,3'b000,6'h01,4'b0100,4'b0000,4'd9},  // R9
    '{1'b0,2'd2,2'd0,2'd0,2'd0,1'b0,1'b0,3'b000,6'h04,4'b0001,4'b0000,4'd3},  // R3
    '{1'b0,2'd3,2'd3,2'd0,2'd3,1'b1,1'b0,3'b111,6'h07,4'b0000,4'b0000,4'd3},  // R3
    '{1'b0,2'd1,2'd1,2'd0,2'd0,1'b1,1'b1,3'b100,6'h01,4'b0100,4'b1000,4'd10}, // R10
    '{1'b0,2'd1,2'd1,2'd0,2'd0,1'b1,1'b1,3'b100,6'h20,4'b0000,4'b0000,4'd10}  // R10
  };

  logic       clk;
  logic       rst_n;
  logic [3:0] gclk_in;
  logic [1:0] pterm_in;
  logic [2:0] en_in;
  logic       cfg_load;
  logic       cfg_l0_pt;
  logic [1:0] cfg_l0_sel;
  logic [1:0] cfg_l1_sel;
  logic [1:0] cfg_l1_mode;
  logic [1:0] cfg_l2_sel;
  logic       cfg_l2_use_en;
  logic       cfg_l3_pt;
  logic [3:0] strobe;
  logic       cfg_err;

  int n_checks;
  int n_fail;
  bit done;

  blkclk_gen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .gclk_in       (gclk_in),
    .pterm_in      (pterm_in),
    .en_in         (en_in),
    .cfg_load      (cfg_load),
    .cfg_l0_pt     (cfg_l0_pt),
    .cfg_l0_sel    (cfg_l0_sel),
    .cfg_l1_sel    (cfg_l1_sel),
    .cfg_l1_mode   (cfg_l1_mode),
    .cfg_l2_sel    (cfg_l2_sel),
    .cfg_l2_use_en (cfg_l2_use_en),
    .cfg_l3_pt     (cfg_l3_pt),
    .strobe        (strobe),
    .cfg_err       (cfg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic collect(output logic [3:0] acc);
    acc = '0;
    repeat (5) begin
      @(negedge clk);
      acc |= strobe;
    end
  endtask

  task automatic load_vec(input vec_t v);
    @(negedge clk);
    cfg_l0_pt     = v.l0pt;
    cfg_l0_sel    = v.l0sel;
    cfg_l1_sel    = v.l1sel;
    cfg_l1_mode   = v.l1mode;
    cfg_l2_sel    = v.l2sel;
    cfg_l2_use_en = v.l2en;
    cfg_l3_pt     = v.l3pt;
    cfg_load      = 1'b1;
    @(negedge clk);
    cfg_load      = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [3:0] acc;
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n = 1'b0; gclk_in = '0; pterm_in = '0; en_in = '0; cfg_load = 1'b0;
    cfg_l0_pt = 1'b0; cfg_l0_sel = '0; cfg_l1_sel = '0; cfg_l1_mode = '0;
    cfg_l2_sel = '0; cfg_l2_use_en = 1'b0; cfg_l3_pt = 1'b0;
    idle(3);
    gclk_in = 4'hF;  // activity during reset must not strobe
    idle(3);
    check(strobe == 4'b0000, "R1 strobe in reset", strobe, 0);
    check(cfg_err == 1'b0, "R1 cfg_err in reset", cfg_err, 0);
    gclk_in = '0;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    // R2: exact latency and width on line 0 (default: gclk 0, pin)
    gclk_in = 4'h1;
    @(negedge clk); check(strobe[0] == 1'b0, "R2 cycle1", strobe, 0);
    @(negedge clk); check(strobe[0] == 1'b0, "R2 cycle2", strobe, 0);
    @(negedge clk); check(strobe == 4'b0101, "R2 cycle3", strobe, 4'b0101);
    @(negedge clk); check(strobe == 4'b0000, "R2 cycle4", strobe, 0);
    gclk_in = '0;
    idle(6);

    // R11: select change without load has no effect
    en_in = 3'b001;
    cfg_l0_sel = 2'd1; cfg_l1_sel = 2'd1;
    idle(2);
    gclk_in = 4'h1;
    collect(acc);
    check(acc == 4'b0111, "R11 old select still active", acc, 4'b0111);
    gclk_in = 4'h0;
    idle(6);
    gclk_in = 4'h2;
    collect(acc);
    check(acc == 4'b0000, "R11 new select not active", acc, 0);
    gclk_in = 4'h0;
    en_in = '0;
    idle(6);

    // table walk
    for (int i = 0; i < NV; i++) begin
      load_vec(VEC[i]);
      en_in = VEC[i].en;
      idle(4);
      gclk_in  = VEC[i].stim[3:0];
      pterm_in = VEC[i].stim[5:4];
      collect(acc);
      n_checks++;
      if (acc != VEC[i].erise) begin
        n_fail++;
        $display("FAIL R%0d vec %0d rise actual=%b expected=%b", VEC[i].req, i, acc, VEC[i].erise);
      end
      gclk_in  = '0;
      pterm_in = '0;
      collect(acc);
      n_checks++;
      if (acc != VEC[i].efall) begin
        n_fail++;
        $display("FAIL R%0d vec %0d fall actual=%b expected=%b", VEC[i].req, i, acc, VEC[i].efall);
      end
      idle(2);
    end
    en_in = '0;

    // R10: flag set by illegal load and sticky across a legal load
    check(cfg_err == 1'b1, "R10 error flag set", cfg_err, 1);
    load_vec(VEC[0]);
    idle(2);
    check(cfg_err == 1'b1, "R10 error flag sticky", cfg_err, 1);

    // R1: reset clears the flag and restores the default configuration
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(cfg_err == 1'b0, "R1 reset clears cfg_err", cfg_err, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    gclk_in = 4'h1;
    collect(acc);
    check(acc == 4'b0101, "R1 default config rise", acc, 4'b0101);
    gclk_in = 4'h0;
    collect(acc);
    check(acc == 4'b1000, "R1 default config fall", acc, 4'b1000);

    done = 1'b1;
    finish_run();
  end

endmodule